// File: doc/BRIEF.md
# Table-Lookup Bit-Serial Dot-Product Engine

This block forms signed dot products between a vector of int8 activations and columns of low-precision weights without a single multiplier. After a start pulse it captures the activation vector, then builds, for each group of four activations, a table of signed partial sums, one entry for each sign pattern the group's weight bits can produce. Weights arrive afterwards as bit-planes. The four bits that one plane holds for one group select a table entry, and the selected entries are added into an accumulator after a left shift by the plane number.

Each weight bit stands for +1 when set and -1 when clear, so an n-bit code q stands for the odd value 2q - (2^n - 1). The table keeps only the eight patterns whose top index bit is clear. A pattern with that bit set is read as the negated entry of its bitwise complement. A single table fill serves a programmable number of weight columns, and the block produces one result per column.

Top module: `lut_dot_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, act_ready_o, idx_ready_o, res_valid_o and done_o are all low.
- R2: start_i samples wsel_i and ncols_m1_i. wsel_i = 0 selects 1 bit-plane, 1 selects 2, and 2 or 3 select 4. Later changes to these inputs have no effect on the job.
- R3: After start, act_ready_o is high until DOT_LEN activations have been accepted, one per valid/ready handshake, in element order 0 to DOT_LEN-1. It then drops.
- R4: Table precompute takes 8 cycles per activation group, DOT_LEN/4 x 8 cycles in total, counted from the cycle after the last activation handshake. During that time neither ready is high, and idx_ready_o rises as soon as it ends. The two readies are never high together.
- R5: A column takes DOT_LEN/4 x n index beats in plane-major order: plane 0 first, and within each plane the groups in ascending order. In a beat, bit i of idx_bits_i is the current plane's bit of activation 4g+i. Cycles without idx_valid_i do not advance the sequence.
- R6: res_data_o equals the sum over k of a_k x (2 q_k - (2^n - 1)) as a signed ACC_W-bit value. The extreme inputs (all activations -128 with all codes 0 or all codes at maximum) must give the exact result without wrap.
- R7: res_valid_o is high for exactly the one cycle after a column's final index handshake and at no other time. Each column starts from a zero sum.
- R8: ncols_m1_i + 1 columns are processed on one table fill. done_o is high for one cycle, the cycle after the last column's result, and idx_ready_o is low from the last result onward.
- R9: start_i has no effect while a job is in progress. The job's results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begins a job when the block is idle |
| wsel_i | input | 2 | Weight width select, sampled at start |
| ncols_m1_i | input | COL_W | Columns per table fill, minus one |
| act_valid_i | input | 1 | Activation beat valid |
| act_ready_o | output | 1 | Block accepts activations |
| act_data_i | input | ACT_W | Signed activation |
| idx_valid_i | input | 1 | Index beat valid |
| idx_ready_o | output | 1 | Block accepts index beats |
| idx_bits_i | input | 4 | One plane's bits for one group |
| res_valid_o | output | 1 | Column result valid, one cycle |
| res_data_o | output | ACC_W | Signed column result |
| done_o | output | 1 | Job finished, one cycle |

## Verification
A wrong table entry, a wrong complement or negation path, or a wrong plane shift shows up as a wrong res_data_o in the cycle right after that column's last index beat. The bench chooses activation and weight patterns that exercise every sign pattern and every plane. A counter off by one in the group, plane or column sequence moves res_valid_o or done_o by at least one beat, and the bench checks after every handshake whether a result is present. A precompute count that is wrong shows as idx_ready_o rising in the wrong cycle, which the bench counts exactly.

// File: rtl/lut_dot_pkg.sv
package lut_dot_pkg;

   localparam int GRP_SIZE  = 4;
   localparam int HALF_ENTS = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_FILL,
      ST_RUN,
      ST_FIN,
      ST_DONE
   } dot_state_e;

   // index of the last bit-plane for a width select code
   function automatic logic [1:0] last_plane(input logic [1:0] sel);
      case (sel)
         2'd0:    return 2'd0;
         2'd1:    return 2'd1;
         default: return 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/lut_dot_table.sv
module lut_dot_table
   import lut_dot_pkg::*;
#(
   parameter int ACT_W = 8,
   parameter int NGRP  = 2,
   parameter int ENT_W = ACT_W + 3,
   localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           fill_en,
   input  logic [GW-1:0]                  fill_grp,
   input  logic [2:0]                     fill_pat,
   input  logic [NGRP*GRP_SIZE*ACT_W-1:0] acts_i,
   input  logic [GW-1:0]                  rd_grp,
   input  logic [3:0]                     rd_idx,
   output logic signed [ENT_W-1:0]        rd_val
);

   logic signed [ENT_W-1:0] fill_sum;
   logic signed [ENT_W-1:0] grp_rd [NGRP];
   logic [2:0]              rd_lo;
   logic signed [ENT_W-1:0] raw;

   // partial sum of the group being filled; element 3 always takes the minus sign
   always_comb begin
      fill_sum = '0;
      for (int i = 0; i < GRP_SIZE; i++) begin
         logic signed [ACT_W-1:0] a;
         logic signed [ENT_W-1:0] ax;
         a  = acts_i[(int'(fill_grp) * GRP_SIZE + i) * ACT_W +: ACT_W];
         ax = {{(ENT_W-ACT_W){a[ACT_W-1]}}, a};
         if (i < GRP_SIZE - 1 && fill_pat[i])
            fill_sum = fill_sum + ax;
         else
            fill_sum = fill_sum - ax;
      end
   end

   // symmetric half table: top index bit set reads the complement and negates
   assign rd_lo = rd_idx[3] ? ~rd_idx[2:0] : rd_idx[2:0];

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic signed [ENT_W-1:0] ent_q [HALF_ENTS];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int e = 0; e < HALF_ENTS; e++) ent_q[e] <= '0;
         end else if (fill_en && fill_grp == GW'(g)) begin
            ent_q[fill_pat] <= fill_sum;
         end
      end
      assign grp_rd[g] = ent_q[rd_lo];
   end

   assign raw    = grp_rd[rd_grp];
   assign rd_val = rd_idx[3] ? -raw : raw;

endmodule

// File: rtl/lut_dot_acc.sv
module lut_dot_acc #(
   parameter int ENT_W = 11,
   parameter int ACC_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    add_en,
   input  logic signed [ENT_W-1:0] term_i,
   input  logic [1:0]              plane_i,
   output logic signed [ACC_W-1:0] sum_o
);

   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] term_x;
   logic signed [ACC_W-1:0] scaled;

   assign term_x = {{(ACC_W-ENT_W){term_i[ENT_W-1]}}, term_i};
   assign scaled = term_x <<< plane_i;
   assign sum_o  = acc_q + scaled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acc_q <= '0;
      else if (clr)    acc_q <= '0;
      else if (add_en) acc_q <= sum_o;
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      add_en |-> !((acc_q[ACC_W-1] == scaled[ACC_W-1]) && (sum_o[ACC_W-1] != acc_q[ACC_W-1])));

endmodule

// File: rtl/lut_dot_unit.sv
module lut_dot_unit
   import lut_dot_pkg::*;
#(
   parameter int ACT_W   = 8,
   parameter int DOT_LEN = 8,
   parameter int COL_W   = 4,
   parameter int ACC_W   = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [1:0]         wsel_i,
   input  logic [COL_W-1:0]   ncols_m1_i,
   input  logic               act_valid_i,
   output logic               act_ready_o,
   input  logic [ACT_W-1:0]   act_data_i,
   input  logic               idx_valid_i,
   output logic               idx_ready_o,
   input  logic [3:0]         idx_bits_i,
   output logic               res_valid_o,
   output logic [ACC_W-1:0]   res_data_o,
   output logic               done_o
);

   localparam int NGRP   = DOT_LEN / GRP_SIZE;
   localparam int GW     = (NGRP > 1) ? $clog2(NGRP) : 1;
   localparam int ENT_W  = ACT_W + 3;
   localparam int FILL_N = NGRP * HALF_ENTS;
   localparam int FW     = $clog2(FILL_N);
   localparam int KW     = $clog2(DOT_LEN);

   if (DOT_LEN % GRP_SIZE != 0 || DOT_LEN < GRP_SIZE) begin : g_bad_len
      $error("DOT_LEN must be a positive multiple of the group size");
   end
   if (ACC_W < ENT_W + 3 + $clog2(NGRP + 1) + 1) begin : g_bad_acc
      $error("ACC_W too narrow for the worst-case sum");
   end

   dot_state_e                   state_q;
   logic [1:0]                   pl_last_q;
   logic [COL_W-1:0]             cols_q;
   logic [KW-1:0]                act_cnt;
   logic [DOT_LEN*ACT_W-1:0]     acts_q;
   logic [FW-1:0]                fill_cnt;
   logic [GW-1:0]                fill_grp;
   logic [GW-1:0]                g_cnt;
   logic [1:0]                   p_cnt;
   logic [COL_W-1:0]             c_cnt;
   logic                         act_beat, beat, last_g, last_p, col_end;
   logic                         res_valid_q;
   logic [ACC_W-1:0]             res_data_q;
   logic signed [ENT_W-1:0]      term;
   logic signed [ACC_W-1:0]      acc_sum;

   if (NGRP > 1) begin : g_multi
      assign fill_grp = fill_cnt[FW-1:3];
   end else begin : g_single
      assign fill_grp = '0;
   end

   assign act_ready_o = (state_q == ST_LOAD);
   assign idx_ready_o = (state_q == ST_RUN);
   assign done_o      = (state_q == ST_DONE);
   assign res_valid_o = res_valid_q;
   assign res_data_o  = res_data_q;

   assign act_beat = act_valid_i && act_ready_o;
   assign beat     = idx_valid_i && idx_ready_o;
   assign last_g   = (g_cnt == GW'(NGRP - 1));
   assign last_p   = (p_cnt == pl_last_q);
   assign col_end  = beat && last_g && last_p;

   lut_dot_table #(.ACT_W(ACT_W), .NGRP(NGRP), .ENT_W(ENT_W)) table_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fill_en  (state_q == ST_FILL),
      .fill_grp (fill_grp),
      .fill_pat (fill_cnt[2:0]),
      .acts_i   (acts_q),
      .rd_grp   (g_cnt),
      .rd_idx   (idx_bits_i),
      .rd_val   (term)
   );

   lut_dot_acc #(.ENT_W(ENT_W), .ACC_W(ACC_W)) acc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     ((state_q == ST_IDLE && start_i) || col_end),
      .add_en  (beat),
      .term_i  (term),
      .plane_i (p_cnt),
      .sum_o   (acc_sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         pl_last_q <= '0;
         cols_q    <= '0;
         act_cnt   <= '0;
         acts_q    <= '0;
         fill_cnt  <= '0;
         g_cnt     <= '0;
         p_cnt     <= '0;
         c_cnt     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start_i) begin
               pl_last_q <= last_plane(wsel_i);
               cols_q    <= ncols_m1_i;
               act_cnt   <= '0;
               state_q   <= ST_LOAD;
            end
            ST_LOAD: if (act_beat) begin
               acts_q[act_cnt*ACT_W +: ACT_W] <= act_data_i;
               act_cnt <= act_cnt + 1'b1;
               if (act_cnt == KW'(DOT_LEN - 1)) begin
                  fill_cnt <= '0;
                  state_q  <= ST_FILL;
               end
            end
            ST_FILL: begin
               fill_cnt <= fill_cnt + 1'b1;
               if (fill_cnt == FW'(FILL_N - 1)) begin
                  g_cnt   <= '0;
                  p_cnt   <= '0;
                  c_cnt   <= '0;
                  state_q <= ST_RUN;
               end
            end
            ST_RUN: if (beat) begin
               if (!last_g) begin
                  g_cnt <= g_cnt + 1'b1;
               end else begin
                  g_cnt <= '0;
                  if (!last_p) begin
                     p_cnt <= p_cnt + 1'b1;
                  end else begin
                     p_cnt <= '0;
                     c_cnt <= c_cnt + 1'b1;
                     if (c_cnt == cols_q) state_q <= ST_FIN;
                  end
               end
            end
            ST_FIN:  state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid_q <= 1'b0;
         res_data_q  <= '0;
      end else begin
         res_valid_q <= col_end;
         if (col_end) res_data_q <= acc_sum;
      end
   end

   // R4
   ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(act_ready_o && idx_ready_o));

   // R7
   res_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> $past(idx_valid_i && idx_ready_o));

   // R8
   done_after_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(res_valid_o) && !idx_ready_o));

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R9
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_ready_o && start_i) |=> !act_ready_o);

endmodule

// File: tb/lut_dot_unit_tb_top.sv
`timescale 1ns/1ps
module lut_dot_unit_tb_top;

   localparam int ACT_W = 8;
   localparam int K     = 8;
   localparam int COL_W = 4;
   localparam int ACC_W = 24;
   localparam int NG    = K / 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [1:0]       wsel = '0;
   logic [COL_W-1:0] ncols_m1 = '0;
   logic             act_valid = 1'b0;
   logic             act_ready;
   logic [ACT_W-1:0] act_data = '0;
   logic             idx_valid = 1'b0;
   logic             idx_ready;
   logic [3:0]       idx_bits = '0;
   logic             res_valid;
   logic [ACC_W-1:0] res_data;
   logic             done;

   int errs = 0;
   int checks = 0;
   bit finished = 1'b0;
   int acts [K];
   int wq [4][K];

   always #2.5 clk = ~clk;

   lut_dot_unit #(.ACT_W(ACT_W), .DOT_LEN(K), .COL_W(COL_W), .ACC_W(ACC_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .wsel_i(wsel), .ncols_m1_i(ncols_m1),
      .act_valid_i(act_valid), .act_ready_o(act_ready), .act_data_i(act_data),
      .idx_valid_i(idx_valid), .idx_ready_o(idx_ready), .idx_bits_i(idx_bits),
      .res_valid_o(res_valid), .res_data_o(res_data), .done_o(done)
   );

   task automatic check(input string req, input string what, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errs++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
      end
   endtask

   // one complete job; caller has filled acts and wq
   task automatic run_job(input int sel, input int ncol, input bit gaps, input bit noise);
      int n = (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
      int cyc;
      int acth;
      int expv;
      logic [3:0] d;
      @(negedge clk);
      start = 1'b1; wsel = 2'(sel); ncols_m1 = COL_W'(ncol - 1);
      @(negedge clk);
      start = 1'b0; wsel = ~2'(sel); ncols_m1 = '1;   // R2: later changes ignored
      check("R3", "act_ready after start", int'(act_ready), 1);
      for (int k = 0; k < K; k++) begin
         act_valid = 1'b1; act_data = ACT_W'(acts[k]);
         while (!act_ready) @(negedge clk);
         @(negedge clk);
      end
      act_valid = 1'b0;
      cyc = 0; acth = 0;
      while (!idx_ready && cyc < 200) begin
         acth += int'(act_ready);
         cyc++;
         @(negedge clk);
      end
      check("R4", "precompute cycles", cyc, NG * 8);
      check("R3", "act_ready after last activation", acth, 0);
      for (int c = 0; c < ncol; c++) begin
         expv = 0;
         for (int k = 0; k < K; k++) expv += acts[k] * (2 * wq[c][k] - ((1 << n) - 1));
         for (int j = 0; j < n; j++) begin
            for (int g = 0; g < NG; g++) begin
               for (int i = 0; i < 4; i++) d[i] = 1'((wq[c][4*g+i] >> j) & 1);
               if (gaps && g == 0) begin
                  idx_valid = 1'b0;
                  if (noise) start = 1'b1;      // R9: start while busy
                  @(negedge clk);
                  start = 1'b0;
               end
               idx_valid = 1'b1; idx_bits = d;
               while (!idx_ready) @(negedge clk);
               @(negedge clk);
               if (j == n - 1 && g == NG - 1) begin
                  check("R7", "res_valid after final beat", int'(res_valid), 1);
                  check("R6", "column result", int'($signed(res_data)), expv);
               end else begin
                  check("R5", "no result mid-column", int'(res_valid), 0);
               end
            end
         end
      end
      idx_valid = 1'b0;
      check("R8", "idx_ready low after last result", int'(idx_ready), 0);
      @(negedge clk);
      check("R8", "done after last result", int'(done), 1);
      check("R7", "res_valid single cycle", int'(res_valid), 0);
      @(negedge clk);
      check("R8", "done single cycle", int'(done), 0);
      check("R9", "act_ready idle after job", int'(act_ready), 0);
   endtask

   task automatic test_reset();
      check("R1", "act_ready in reset", int'(act_ready), 0);
      check("R1", "idx_ready in reset", int'(idx_ready), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1", "res_valid after reset", int'(res_valid), 0);
      check("R1", "done after reset", int'(done), 0);
      check("R1", "idx_ready after reset", int'(idx_ready), 0);
   endtask

   task automatic test_one_bit();
      int v [K] = '{5, -3, 17, -128, 127, 0, -64, 33};
      for (int k = 0; k < K; k++) begin acts[k] = v[k]; wq[0][k] = (k * 5 + 1) % 2; end
      run_job(0, 1, 1'b0, 1'b0);   // R2 width 1
   endtask

   task automatic test_two_bit_reuse();
      for (int k = 0; k < K; k++) begin
         acts[k] = (k * 37 + 11) % 256 - 128;
         for (int c = 0; c < 3; c++) wq[c][k] = (k * 3 + c * 7 + 2) % 4;
      end
      run_job(1, 3, 1'b0, 1'b0);   // R8 three columns on one fill
   endtask

   task automatic test_four_bit_stall();
      for (int k = 0; k < K; k++) begin
         acts[k] = (k * 91 + 45) % 256 - 128;
         for (int c = 0; c < 2; c++) wq[c][k] = (k * 5 + c * 9 + 3) % 16;
      end
      run_job(2, 2, 1'b1, 1'b1);   // R5 stalls, R9 start noise
   endtask

   task automatic test_extreme();
      for (int k = 0; k < K; k++) begin acts[k] = -128; wq[0][k] = 0; wq[1][k] = 15; end
      run_job(3, 2, 1'b0, 1'b0);   // R6 +/-15360, code 3 means 4 planes (R2)
   endtask

   initial begin
      test_reset();
      test_one_bit();
      test_two_bit_reuse();
      test_four_bit_stall();
      test_extreme();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errs++;
         $display("FAIL R8 watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule